// File: doc/BRIEF.md
# Memory Self-Test Engine with Serial Result Register

The block tests a small synchronous RAM held inside it. A one-cycle run request in the test-clock domain starts a March C- sweep. The sweep runs on a separate self-test clock and does six elements over every address, 10 × DEPTH single-cycle operations in all. Each read is compared with the value the march expects, and the number of miscompares is accumulated in a saturating counter.

When the sweep ends, a done toggle is passed back to the test clock through a two-flop synchronizer. The test-clock side then loads a result word that can be shifted out serially. Bit 0 of that word is a filler bit, bit 1 is the pass flag, and the bits above bit 1 hold the miscompare count.

A mode latch is programmed before a run. In normal mode the engine checks the array. In forced-error mode every expected value is inverted, so the engine has to report a failure. This shows that the reporting path works. The run request and the done indication cross the clock boundary as toggles through two-flop synchronizers. An active-low asynchronous reset clears both clock domains and holds the engine idle.

Top module: `mbist_top`

## Requirements
- R1: While rst_ni is low, busy_o, done_o and scan_o are 0. A run_i pulse given during reset starts nothing.
- R2: A run_i pulse seen at a tck_i edge while busy_o is 0 starts a run. busy_o is 1 and done_o is 0 after that edge, and both keep those values until the run ends.
- R3: A run performs exactly 10 × DEPTH self-test operations (March C-). done_o rises, and busy_o falls, between OPS × Tbist / Ttck and that value plus 8 tck_i cycles after the launching edge.
- R4: In normal mode (mode_force_i = 0 when written) with a healthy array, the pass flag is 1 and the count is 0.
- R5: In forced-error mode (mode_force_i = 1 when written), every one of the 5 × DEPTH reads counts as a failure and the pass flag is 0.
- R6: The failure count saturates at 2^CNT_W − 1 and does not wrap.
- R7: The result word is CNT_W + 2 bits wide. Bit 0 is a filler and reads 0. Bit 1 is the pass flag: 1 means no failure was seen, 0 means at least one was seen. Bits CNT_W+1..2 hold the count, with its LSB at bit 2.
- R8: While shift_en_i is 1 and busy_o is 0, the result word shifts right by one bit each tck_i cycle. scan_o shows the current bit 0, and scan_i enters at the MSB.
- R9: While busy_o is 1, mode writes and run_i pulses are ignored. The running test keeps its mode and length, and no second run follows it.
- R10: The mode latch keeps its value from one run to the next until it is written again while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| bist_clk_i | input | 1 | Self-test clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| run_i | input | 1 | Run request pulse (tck domain) |
| mode_we_i | input | 1 | Mode latch write strobe |
| mode_force_i | input | 1 | Mode value: 1 = forced error, 0 = normal |
| shift_en_i | input | 1 | Result register shift enable |
| scan_i | input | 1 | Serial input to the result register MSB |
| scan_o | output | 1 | Serial output, result register bit 0 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Result loaded, held until the next run |

## Verification
The first normal-mode run on a healthy array should read back a pass flag of 1 and a zero count. That separates a correct compare from an inverted or stuck one. A forced-error run with DEPTH = 8 and CNT_W = 5 makes 40 miscompares against a ceiling of 31. A result of 31 shows the counter saturates, while 8 would reveal a wrapping counter and 0 would show the mode was never applied. A mode write and a run pulse given during that forced run, followed by a repeat run with no new mode write, show that the latch holds its value and that requests are ignored while busy. An alternating pattern shifted in behind each result is checked bit by bit by a queue model. Every run's completion time is checked against the window given by the clock ratio.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int unsigned NUM_ELEM = 6;
  localparam logic [2:0] LAST_ELEM = 3'd5;

  // March C-: up w0; up r0w1; up r1w0; dn r0w1; dn r1w0; up r0
  function automatic logic elem_up(input logic [2:0] e);
    return !(e == 3'd3 || e == 3'd4);
  endfunction

  function automatic logic elem_rw(input logic [2:0] e);
    return e >= 3'd1 && e <= 3'd4;
  endfunction

  function automatic logic elem_has_rd(input logic [2:0] e);
    return e != 3'd0;
  endfunction

  function automatic logic elem_exp_one(input logic [2:0] e);
    return e == 3'd2 || e == 3'd4;
  endfunction

  function automatic logic elem_wr_one(input logic [2:0] e);
    return e == 3'd1 || e == 3'd3;
  endfunction
endpackage

// File: rtl/mbist_sync.sv
module mbist_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mbist_march.sv
module mbist_march import mbist_pkg::*; #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_tgl_i,
  input  logic             force_i,
  output logic             done_tgl_o,
  output logic [CNT_W-1:0] fail_cnt_o,
  output logic             pass_o
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned OPS    = 10 * DEPTH;
  localparam int unsigned OPW    = $clog2(OPS);
  localparam logic [ADDR_W-1:0] ADDR_MAX = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              run_q, phase_q, start_d_q, force_q, done_tgl_q;
  logic [2:0]        elem_q;
  logic [ADDR_W-1:0] addr_q, addr_first;
  logic [CNT_W-1:0]  cnt_q;
  logic [OPW-1:0]    op_q;
  logic              start_pls, rd_op, wr_op, miss, step_done, last_addr, finish;
  logic [DATA_W-1:0] exp_data;

  assign start_pls  = start_tgl_i ^ start_d_q;
  assign rd_op      = run_q && elem_has_rd(elem_q) && !phase_q;
  assign wr_op      = run_q && (elem_q == 3'd0 || (elem_rw(elem_q) && phase_q));
  assign exp_data   = {DATA_W{elem_exp_one(elem_q) ^ force_q}};
  assign miss       = rd_op && (mem[addr_q] != exp_data);
  assign step_done  = !(elem_rw(elem_q) && !phase_q);
  assign last_addr  = elem_up(elem_q) ? (addr_q == ADDR_MAX) : (addr_q == '0);
  assign finish     = run_q && step_done && last_addr && elem_q == LAST_ELEM;
  assign addr_first = elem_up(elem_q + 3'd1) ? '0 : ADDR_MAX;

  always_ff @(posedge clk_i) begin
    if (wr_op) mem[addr_q] <= {DATA_W{elem_wr_one(elem_q)}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      phase_q    <= 1'b0;
      start_d_q  <= 1'b0;
      force_q    <= 1'b0;
      done_tgl_q <= 1'b0;
      elem_q     <= '0;
      addr_q     <= '0;
      cnt_q      <= '0;
      op_q       <= '0;
    end else begin
      start_d_q <= start_tgl_i;
      if (!run_q) begin
        if (start_pls) begin
          run_q   <= 1'b1;
          force_q <= force_i;
          elem_q  <= '0;
          addr_q  <= '0;
          phase_q <= 1'b0;
          cnt_q   <= '0;
          op_q    <= '0;
        end
      end else begin
        op_q <= op_q + 1'b1;
        if (miss && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (!step_done) begin
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          if (finish) begin
            run_q      <= 1'b0;
            done_tgl_q <= ~done_tgl_q;
          end else if (last_addr) begin
            elem_q <= elem_q + 3'd1;
            addr_q <= addr_first;
          end else begin
            addr_q <= elem_up(elem_q) ? addr_q + 1'b1 : addr_q - 1'b1;
          end
        end
      end
    end
  end

  assign done_tgl_o = done_tgl_q;
  assign fail_cnt_o = cnt_q;
  assign pass_o     = (cnt_q == '0);

  // R3
  op_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |-> op_q == OPW'(OPS - 1));
  // R5
  forced_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_op && force_q |=> cnt_q != '0);
  // R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> cnt_q >= $past(cnt_q));
  // R6
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             mode_we_i,
  input  logic             mode_force_i,
  input  logic             shift_en_i,
  input  logic             scan_i,
  input  logic             done_tgl_i,
  input  logic [CNT_W-1:0] fail_cnt_i,
  input  logic             pass_i,
  output logic             start_tgl_o,
  output logic             force_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             scan_o
);
  localparam int unsigned RES_W = CNT_W + 2;

  logic             start_tgl_q, force_q, busy_q, done_q, done_d_q;
  logic [RES_W-1:0] res_q;
  logic             done_pls;

  assign done_pls = done_tgl_i ^ done_d_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_tgl_q <= 1'b0;
      force_q     <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      done_d_q    <= 1'b0;
      res_q       <= '0;
    end else begin
      done_d_q <= done_tgl_i;
      if (busy_q) begin
        if (done_pls) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= {fail_cnt_i, pass_i, 1'b0};
        end
      end else if (run_i) begin
        start_tgl_q <= ~start_tgl_q;
        busy_q      <= 1'b1;
        done_q      <= 1'b0;
      end else begin
        if (mode_we_i) force_q <= mode_force_i;
        if (shift_en_i) res_q <= {scan_i, res_q[RES_W-1:1]};
      end
    end
  end

  assign start_tgl_o = start_tgl_q;
  assign force_o     = force_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign scan_o      = res_q[0];

  // R2
  launch_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    run_i && !busy_o |=> busy_o && !done_o);
  // R9
  mode_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    busy_o && mode_we_i |=> force_o == $past(force_o));
  // R7
  layout_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(done_o) |-> res_q[1] == (res_q[RES_W-1:2] == '0) && !res_q[0]);
  // R8
  shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    shift_en_i && !busy_o && !run_i |=> res_q[RES_W-2:0] == $past(res_q[RES_W-1:1]));
endmodule

// File: rtl/mbist_top.sv
module mbist_top #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic tck_i,
  input  logic bist_clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mode_we_i,
  input  logic mode_force_i,
  input  logic shift_en_i,
  input  logic scan_i,
  output logic scan_o,
  output logic busy_o,
  output logic done_o
);
  logic             start_tgl, start_tgl_s, done_tgl, done_tgl_s, force_l, pass;
  logic [CNT_W-1:0] fail_cnt;

  mbist_sync u_start_sync (
    .clk_i(bist_clk_i), .rst_ni(rst_ni), .d_i(start_tgl), .q_o(start_tgl_s)
  );

  mbist_march #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_march (
    .clk_i(bist_clk_i), .rst_ni(rst_ni), .start_tgl_i(start_tgl_s),
    .force_i(force_l), .done_tgl_o(done_tgl), .fail_cnt_o(fail_cnt), .pass_o(pass)
  );

  mbist_sync u_done_sync (
    .clk_i(tck_i), .rst_ni(rst_ni), .d_i(done_tgl), .q_o(done_tgl_s)
  );

  mbist_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .tck_i(tck_i), .rst_ni(rst_ni), .run_i(run_i), .mode_we_i(mode_we_i),
    .mode_force_i(mode_force_i), .shift_en_i(shift_en_i), .scan_i(scan_i),
    .done_tgl_i(done_tgl_s), .fail_cnt_i(fail_cnt), .pass_i(pass),
    .start_tgl_o(start_tgl), .force_o(force_l), .busy_o(busy_o),
    .done_o(done_o), .scan_o(scan_o)
  );
endmodule

// File: tb/sim_mbist_top.sv
module sim_mbist_top;
  localparam int TCK_P  = 20;
  localparam int BIST_P = 10;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 4;
  localparam int CNT_W  = 5;
  localparam int RES_W  = CNT_W + 2;
  localparam int OPS    = 10 * DEPTH;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int LO_WIN = OPS * BIST_P / TCK_P;

  logic tck = 1'b0, bist_clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, mode_we = 1'b0, mode_force = 1'b0, shift_en = 1'b0, scan_in = 1'b0;
  logic scan_out, busy, done;
  int checks = 0, fails = 0;
  bit finished = 0;
  bit model_q[$];

  always #(TCK_P / 2) tck = ~tck;
  initial begin
    #(BIST_P / 4);
    forever #(BIST_P / 2) bist_clk = ~bist_clk;
  end

  mbist_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .tck_i(tck), .bist_clk_i(bist_clk), .rst_ni(rst_n), .run_i(run),
    .mode_we_i(mode_we), .mode_force_i(mode_force), .shift_en_i(shift_en),
    .scan_i(scan_in), .scan_o(scan_out), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic write_mode(input logic f);
    @(negedge tck);
    mode_we = 1'b1; mode_force = f;
    @(negedge tck);
    mode_we = 1'b0;
  endtask

  // one run, then shift out the result and an alternating tail
  task automatic do_run(input int exp_cnt, input logic exp_pass, input bit poke);
    int n;
    logic [RES_W-1:0] exp_res;
    @(negedge tck);
    run = 1'b1;
    @(negedge tck);
    run = 1'b0;
    n = 1;
    chk("R2 busy after launch", int'(busy), 1);
    chk("R2 done cleared", int'(done), 0);
    while (!done && n < 400) begin
      if (!busy) chk("R2 busy held during run", 0, 1);
      if (poke && n == 5) begin
        mode_we = 1'b1; mode_force = ~mode_force; run = 1'b1;
      end else begin
        mode_we = 1'b0; run = 1'b0;
      end
      @(negedge tck);
      n++;
    end
    mode_we = 1'b0; run = 1'b0;
    chk("R3 done not before window", int'(n >= LO_WIN), 1);
    chk("R3 done within window", int'(n <= LO_WIN + 8), 1);
    chk("R3 busy falls with done", int'(busy), 0);
    exp_res = {CNT_W'(exp_cnt), exp_pass, 1'b0};
    model_q.delete();
    for (int i = 0; i < RES_W; i++) model_q.push_back(exp_res[i]);
    for (int i = 0; i < 2 * RES_W; i++) begin
      chk($sformatf("R8 R7 R4 R5 R6 scan bit %0d", i), int'(scan_out), int'(model_q.pop_front()));
      shift_en = 1'b1;
      scan_in  = i[0];
      model_q.push_back(scan_in);
      @(negedge tck);
    end
    shift_en = 1'b0;
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        @(negedge tck);
        if (busy) chk("R9 no relaunch", int'(busy), 0);
      end
      chk("R9 idle after ignored pulse", int'(busy), 0);
    end
  endtask

  initial begin
    #(TCK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int sat;
    sat = (5 * DEPTH > CMAX) ? CMAX : 5 * DEPTH;
    repeat (3) @(negedge tck);
    run = 1'b1;
    @(negedge tck);
    run = 1'b0;
    repeat (3) @(negedge tck);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 scan in reset", int'(scan_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge tck);
    chk("R1 idle after reset", int'(busy), 0);

    write_mode(1'b0);
    do_run(0, 1'b1, 0);           // R4 normal pass
    write_mode(1'b1);
    do_run(sat, 1'b0, 1);         // R5 R6 forced, saturated; R9 poke while busy
    do_run(sat, 1'b0, 0);         // R10 mode persists
    write_mode(1'b0);
    do_run(0, 1'b1, 0);           // R4 back to normal
    summary();
  end
endmodule